// File: doc/BRIEF.md
# Eight-Function Modular ALU

This block is a purely combinational arithmetic logic unit of configurable width. It takes two operands and a 3-bit operation code and returns a result, a carry-out and a signed overflow flag. It is built from three parts. A bitwise unit forms four logic results side by side. An add/subtract unit runs a single ripple-carry chain. A final two-way selector picks which of the two results reaches the output.

Each opcode bit has one fixed structural job. The top bit chooses between the logic side and the arithmetic side. The middle bit chooses the second adder operand: either B or the constant one. The low bit chooses between adding and subtracting. Subtraction inverts the second operand and forces the first carry-in to one, so increment and decrement come out of the same adder as A+B and A−B.

Top module: `eight_op_alu`

## Requirements
- R1: Opcode 000 gives A AND B, 001 gives A OR B, 010 gives the bitwise inverse of A, and 011 gives A XOR B.
- R2: Opcode 100 gives A+B and opcode 101 gives A−B, both modulo 2^WIDTH. The carry-out equals bit WIDTH of the WIDTH+1-bit sum A + B, or of A + (~B) + 1 when subtracting.
- R3: Opcode 110 gives A+1 and opcode 111 gives A−1, using the constant one as the second operand. For example, A−1 with A=0 gives all ones with carry-out 0, and A+1 with A all ones gives 0 with carry-out 1.
- R4: For opcodes with the top bit equal to 0, the carry-out and overflow outputs are both 0.
- R5: For arithmetic opcodes, overflow is 1 exactly when the carry into the most significant stage differs from the carry out of it. At width 4, 7+7 gives 1110 with overflow 1, and 1001+1001 gives 0010 with overflow 1.
- R6: Adding two operands whose most significant bits differ never sets overflow.
- R7: The width is a parameter (default 4). The behaviour in R1 to R6 holds at width 8 as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand (unused by 010, 110 and 111) |
| op_sel | input | 3 | Operation code |
| f_out | output | WIDTH | Result |
| carry_out | output | 1 | Raw carry out of the top adder stage; 0 for logic opcodes |
| ovf_out | output | 1 | Two's-complement overflow; 0 for logic opcodes |

## Verification
The embedded assertions re-check a few rules whenever the operands or opcode change. Logic opcodes must force both flags low. Overflow must match the sign rule on operands and result. Mixed-sign additions must never flag overflow. The addition and increment results must match plain integer sums. The bench's scenarios are needed to show the exact value of every opcode, including the bitwise functions and subtraction's carry. They also cover the documented wrap-around corners and the same behaviour at width 8. They do this by comparing against an independent integer model, exhaustively at width 4 and with random operands at width 8.

// File: rtl/alu_ops_pkg.sv
package alu_ops_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_NOTA = 3'b010,
        OP_XOR  = 3'b011,
        OP_ADD  = 3'b100,
        OP_SUB  = 3'b101,
        OP_INC  = 3'b110,
        OP_DEC  = 3'b111
    } alu_op_e;

    // Arithmetic-side control, one field per opcode bit role
    typedef struct packed {
        logic use_const;   // second operand is constant one
        logic subtract;    // invert operand, carry-in of one
    } arith_ctl_t;

    function automatic logic picks_arith(alu_op_e op);
        return op[2];
    endfunction

    function automatic arith_ctl_t decode_arith(alu_op_e op);
        arith_ctl_t c;
        c.use_const = op[1];
        c.subtract  = op[0];
        return c;
    endfunction

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    always_comb begin
        s_out = x_in ^ y_in ^ c_in;
        c_out = (x_in & y_in) | (x_in & c_in) | (y_in & c_in);
    end
endmodule

// File: rtl/alu_bitwise_unit.sv
module alu_bitwise_unit #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       pick,
    output logic [WIDTH-1:0] f_out
);
    localparam int NUM_FUNCS = 4;

    logic [WIDTH-1:0] cand [NUM_FUNCS];

    always_comb begin
        cand[0] = a_in & b_in;
        cand[1] = a_in | b_in;
        cand[2] = ~a_in;
        cand[3] = a_in ^ b_in;
        f_out   = cand[pick];
    end
endmodule

// File: rtl/alu_addsub_unit.sv
module alu_addsub_unit
    import alu_ops_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  arith_ctl_t       ctl,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] operand2;
    logic [WIDTH-1:0] operand2_x;
    logic [WIDTH:0]   chain;

    always_comb begin
        operand2   = ctl.use_const ? WIDTH'(1) : b_in;
        operand2_x = ctl.subtract ? ~operand2 : operand2;
        chain[0]   = ctl.subtract;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        alu_full_adder u_fa (
            .x_in  (a_in[i]),
            .y_in  (operand2_x[i]),
            .c_in  (chain[i]),
            .s_out (sum_out[i]),
            .c_out (chain[i+1])
        );
    end

    always_comb begin
        carry_out = chain[WIDTH];
        ovf_out   = chain[MSB] ^ chain[WIDTH];
    end
endmodule

// File: rtl/eight_op_alu.sv
module eight_op_alu
    import alu_ops_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] f_out,
    output logic             carry_out,
    output logic             ovf_out
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    arith_ctl_t       actl;
    logic [WIDTH-1:0] logic_f;
    logic [WIDTH-1:0] arith_f;
    logic             arith_c;
    logic             arith_v;

    always_comb begin
        op   = alu_op_e'(op_sel);
        actl = decode_arith(op);
    end

    alu_bitwise_unit #(.WIDTH(WIDTH)) u_bitwise (
        .a_in  (a_in),
        .b_in  (b_in),
        .pick  (op_sel[1:0]),
        .f_out (logic_f)
    );

    alu_addsub_unit #(.WIDTH(WIDTH)) u_addsub (
        .a_in      (a_in),
        .b_in      (b_in),
        .ctl       (actl),
        .sum_out   (arith_f),
        .carry_out (arith_c),
        .ovf_out   (arith_v)
    );

    always_comb begin
        if (picks_arith(op)) begin
            f_out     = arith_f;
            carry_out = arith_c;
            ovf_out   = arith_v;
        end else begin
            f_out     = logic_f;
            carry_out = 1'b0;
            ovf_out   = 1'b0;
        end
    end

    // Output-level checks against operand relations
    always_comb begin
        if (!op_sel[2]) begin
            p_logic_flags_r4: assert (!carry_out && !ovf_out)
                else $error("R4 flags set on logic opcode");
        end
        if (op_sel == 3'b100) begin
            p_add_sum_r2: assert ({carry_out, f_out} == ({1'b0, a_in} + {1'b0, b_in}))
                else $error("R2 add sum mismatch");
            p_add_sign_r5: assert (ovf_out == ((a_in[MSB] == b_in[MSB]) && (f_out[MSB] != a_in[MSB])))
                else $error("R5 add overflow rule");
            if (a_in[MSB] != b_in[MSB]) begin
                p_no_overflow_r6: assert (!ovf_out)
                    else $error("R6 mixed-sign add overflowed");
            end
        end
        if (op_sel == 3'b101) begin
            p_sub_sign_r5: assert (ovf_out == ((a_in[MSB] != b_in[MSB]) && (f_out[MSB] != a_in[MSB])))
                else $error("R5 sub overflow rule");
        end
        if (op_sel == 3'b110) begin
            p_inc_value_r3: assert (f_out == a_in + WIDTH'(1))
                else $error("R3 increment mismatch");
        end
    end
endmodule

// File: tb/eight_op_alu_bench.sv
`timescale 1ns/1ps
module eight_op_alu_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [3:0] a4, b4, f4;
    logic [2:0] op4;
    logic       c4, v4;
    logic [7:0] a8, b8, f8;
    logic [2:0] op8;
    logic       c8, v8;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    eight_op_alu #(.WIDTH(4)) u_eight_op_alu (
        .a_in(a4), .b_in(b4), .op_sel(op4),
        .f_out(f4), .carry_out(c4), .ovf_out(v4)
    );

    eight_op_alu #(.WIDTH(8)) u_eight_op_alu_w8 (
        .a_in(a8), .b_in(b8), .op_sel(op8),
        .f_out(f8), .carry_out(c8), .ovf_out(v8)
    );

    // Independent model: returns {v, c, f} with f in bits [w-1:0]
    function automatic int model(int w, int a, int b, int op);
        int mask = (1 << w) - 1;
        int f = 0, c = 0, v = 0, y = 0, s = 0, cin = 0;
        a &= mask;
        b &= mask;
        case (op)
            0: f = a & b;
            1: f = a | b;
            2: f = (~a) & mask;
            3: f = a ^ b;
            default: begin
                y   = (op >= 6) ? 1 : b;
                cin = op % 2;
                if (cin == 1) y = (~y) & mask;
                s = a + y + cin;
                f = s & mask;
                c = (s >> w) & 1;
                v = (((a >> (w-1)) & 1) == ((y >> (w-1)) & 1)) &&
                    (((f >> (w-1)) & 1) != ((a >> (w-1)) & 1)) ? 1 : 0;
            end
        endcase
        return (v << (w+1)) | (c << w) | f;
    endfunction

    task automatic apply(int w, int a, int b, int op, string req);
        int got, exp;
        @(posedge clk);
        if (w == 4) begin a4 = 4'(a); b4 = 4'(b); op4 = 3'(op); end
        else        begin a8 = 8'(a); b8 = 8'(b); op8 = 3'(op); end
        @(negedge clk);
        got = (w == 4) ? ((int'(v4) << 5) | (int'(c4) << 4) | int'(f4))
                       : ((int'(v8) << 9) | (int'(c8) << 8) | int'(f8));
        exp = model(w, a, b, op);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s w=%0d op=%0d a=%0h b=%0h actual={v,c,f}=%0h expected=%0h",
                     req, w, op, a, b, got, exp);
        end
    endtask

    task automatic t_idle_state;   // R1: all-zero inputs give zero, flags low
        apply(4, 0, 0, 0, "R1");
        apply(8, 0, 0, 0, "R1");
    endtask

    task automatic t_logic_ops;    // R1, R4
        for (int op = 0; op < 4; op++) begin
            apply(4, 4'hC, 4'hA, op, "R1");
            apply(4, 4'hF, 4'hF, op, "R4");
            apply(8, 8'hF0, 8'h3C, op, "R1");
        end
    endtask

    task automatic t_add_sub;      // R2
        apply(4, 3, 5, 4, "R2");
        apply(4, 15, 1, 4, "R2");
        apply(4, 5, 3, 5, "R2");
        apply(4, 3, 5, 5, "R2");
        apply(4, 6, 6, 5, "R2");
    endtask

    task automatic t_inc_dec;      // R3
        apply(4, 0, 9, 7, "R3");
        apply(4, 15, 9, 6, "R3");
        apply(4, 8, 0, 7, "R3");
        apply(8, 0, 0, 7, "R3");
        apply(8, 255, 0, 6, "R3");
    endtask

    task automatic t_overflow_corners;   // R5
        apply(4, 7, 7, 4, "R5");
        apply(4, 9, 9, 4, "R5");
        apply(4, 8, 1, 5, "R5");
        apply(4, 7, 0, 6, "R5");
        apply(8, 127, 1, 4, "R5");
        apply(8, 128, 128, 4, "R5");
    endtask

    task automatic t_mixed_sign;   // R6
        apply(4, 7, 8, 4, "R6");
        apply(4, 15, 1, 4, "R6");
        apply(8, 127, 128, 4, "R6");
    endtask

    task automatic t_exhaustive_w4;   // R1 to R6 at default width
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    apply(4, a, b, op, "R5");
    endtask

    task automatic t_random_w8;    // R7
        for (int i = 0; i < 2000; i++)
            apply(8, int'($urandom_range(255)), int'($urandom_range(255)),
                  int'($urandom_range(7)), "R7");
    endtask

    initial begin
        a4 = '0; b4 = '0; op4 = '0;
        a8 = '0; b8 = '0; op8 = '0;
        repeat (2) @(posedge clk);
        t_idle_state();
        t_logic_ops();
        t_add_sub();
        t_inc_dec();
        t_overflow_corners();
        t_mixed_sign();
        t_exhaustive_w4();
        t_random_w8();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule